// File: doc/BRIEF.md
# Timer Channel Counter with Phase Counting

This block is the counting core of one timer channel. A bank of count sources (already-divided clock ticks or external pulses) arrives as single-cycle strobes. A select field picks which of them advances the counter. In normal operation the counter only counts up. When phase counting mode is active, a direction input makes each selected pulse count either up or down.

The counter can be reset to zero by a compare-match or capture event strobe from either of two general registers. A two-bit field chooses which of the two, if either, has that effect. Software can load the counter directly. A wrap in either direction raises a sticky status flag. Software clears that flag with a handshake: it first reads the flag while the flag is 1, then writes 0 to it.

Top module: `tmr_chan_counter`

## Requirements
- R1: After reset `cnt_q` is 0 and `ovf_flag` is 0.
- R2: The counter changes on a count pulse only when the source picked by `clk_sel` pulses (`src_tick[clk_sel]`). Pulses on other sources have no effect on `cnt_q`.
- R3: When `phase_mode` is 0, each selected pulse adds 1, whatever `count_down` is. When `phase_mode` is 1, a selected pulse adds 1 if `count_down` is 0 and subtracts 1 if `count_down` is 1.
- R4: A count pulse that takes the counter from all-ones to 0 sets `ovf_flag` on the next cycle.
- R5: A down-count pulse in phase counting mode that takes the counter from 0 to all-ones sets `ovf_flag`.
- R6: The `clr_sel` field selects the clearing event. Code 0 means none, 1 means `evt_a`, 2 means `evt_b` and 3 means none. The selected event loads 0 into the counter, takes priority over a count pulse in the same cycle, and never sets the flag.
- R7: `cnt_wr` loads `cnt_wdata` into the counter, and takes priority over event clearing and counting in the same cycle.
- R8: A `flag_rd` that returns `ovf_flag`=1 arms the flag. A later `flag_wr` with `flag_wdata`=0 then clears it.
- R9: A `flag_wr` with `flag_wdata`=0 leaves the flag set if no armed read came before it. A `flag_rd` that returns 0 cancels the arm, and every `flag_wr` uses up the arm.
- R10: If a wrap happens in the same cycle as a valid clearing write, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | NSRC | Count pulse strobes, one per source |
| clk_sel | input | SELW | Index of the active count source |
| phase_mode | input | 1 | 1 enables up/down counting |
| count_down | input | 1 | Direction in phase counting mode (1 = down) |
| clr_sel | input | 2 | Clearing event select (0 none, 1 A, 2 B, 3 none) |
| evt_a | input | 1 | Compare/capture event on register A |
| evt_b | input | 1 | Compare/capture event on register B |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter write data |
| cnt_q | output | W | Counter value |
| flag_rd | input | 1 | Flag read strobe (read data is `ovf_flag`) |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write data |
| ovf_flag | output | 1 | Overflow/underflow status flag |

## Verification
The bench builds the counter with W=4 and four count sources, so a wrap is only sixteen pulses away. With that size, a long pseudo-random sequence reaches overflow and underflow hundreds of times. It also produces every mix of source selection, clear-source code, direction change and same-cycle priority collision. The flag handshake is swept across every ordering of read, write and wrap, because the bench arithmetic model tracks the arm state cycle by cycle.

// File: rtl/tmr_chan_counter.sv
module tmr_chan_counter #(
  parameter int W    = 16,
  parameter int NSRC = 8,
  parameter int SELW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic [SELW-1:0] clk_sel,
  input  logic            phase_mode,
  input  logic            count_down,
  input  logic [1:0]      clr_sel,
  input  logic            evt_a,
  input  logic            evt_b,
  input  logic            cnt_wr,
  input  logic [W-1:0]    cnt_wdata,
  output logic [W-1:0]    cnt_q,
  input  logic            flag_rd,
  input  logic            flag_wr,
  input  logic            flag_wdata,
  output logic            ovf_flag
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic tick, evt_clr, go_down, wrap, armed, clr_ok;

  assign tick    = (int'(clk_sel) < NSRC) ? src_tick[clk_sel] : 1'b0;
  assign evt_clr = (clr_sel == 2'd1 && evt_a) || (clr_sel == 2'd2 && evt_b);
  assign go_down = phase_mode && count_down;
  assign wrap    = !cnt_wr && !evt_clr && tick &&
                   (go_down ? (cnt_q == '0) : (cnt_q == TOP));
  assign clr_ok  = flag_wr && !flag_wdata && armed;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (cnt_wr)          cnt_q <= cnt_wdata;
    else if (evt_clr)         cnt_q <= '0;
    else if (tick && go_down) cnt_q <= cnt_q - 1'b1;
    else if (tick)            cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (wrap)        ovf_flag <= 1'b1;
      else if (clr_ok) ovf_flag <= 1'b0;
      if (flag_wr)      armed <= 1'b0;
      else if (flag_rd) armed <= ovf_flag;
    end
  end
endmodule

// File: rtl/tmr_chan_counter_chk.sv
module tmr_chan_counter_chk #(
  parameter int W    = 16,
  parameter int NSRC = 8,
  parameter int SELW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_tick,
  input logic [SELW-1:0] clk_sel,
  input logic            phase_mode,
  input logic            count_down,
  input logic [1:0]      clr_sel,
  input logic            evt_a,
  input logic            evt_b,
  input logic            cnt_wr,
  input logic [W-1:0]    cnt_wdata,
  input logic [W-1:0]    cnt_q,
  input logic            flag_wr,
  input logic            flag_wdata,
  input logic            ovf_flag
);
  logic sel_tick, sel_evt;
  assign sel_tick = (int'(clk_sel) < NSRC) ? src_tick[clk_sel] : 1'b0;
  assign sel_evt  = (clr_sel == 2'd1) ? evt_a : (clr_sel == 2'd2) ? evt_b : 1'b0;

  // R7
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(cnt_wdata));

  // R6
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && sel_evt) |=> cnt_q == '0);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !sel_evt && !sel_tick) |=> $stable(cnt_q));

  // R3
  up_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !sel_evt && sel_tick && !phase_mode) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (($past(cnt_q) == {W{1'b1}} && cnt_q == '0) ||
                         ($past(cnt_q) == '0 && cnt_q == {W{1'b1}})));

  // R9
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(flag_wr && !flag_wdata));
endmodule

bind tmr_chan_counter tmr_chan_counter_chk #(.W(W), .NSRC(NSRC), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .clk_sel(clk_sel),
  .phase_mode(phase_mode), .count_down(count_down), .clr_sel(clr_sel),
  .evt_a(evt_a), .evt_b(evt_b), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .cnt_q(cnt_q), .flag_wr(flag_wr), .flag_wdata(flag_wdata), .ovf_flag(ovf_flag)
);

// File: tb/tb_tmr_chan_counter.sv
`timescale 1ns/1ps
module tb_tmr_chan_counter;
  localparam int W = 4, NSRC = 4, SELW = 2;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_tick = '0;
  logic [SELW-1:0] clk_sel = '0;
  logic phase_mode = 0, count_down = 0, evt_a = 0, evt_b = 0;
  logic [1:0] clr_sel = '0;
  logic cnt_wr = 0, flag_rd = 0, flag_wr = 0, flag_wdata = 0;
  logic [W-1:0] cnt_wdata = '0, cnt_q;
  logic ovf_flag;

  int total = 0, bad = 0;
  logic [W-1:0] m_cnt = '0;
  logic m_flag = 0, m_arm = 0;
  logic done = 0;

  always #10 clk = ~clk;

  tmr_chan_counter #(.W(W), .NSRC(NSRC), .SELW(SELW)) dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .clk_sel(clk_sel),
    .phase_mode(phase_mode), .count_down(count_down), .clr_sel(clr_sel),
    .evt_a(evt_a), .evt_b(evt_b), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt_q(cnt_q), .flag_rd(flag_rd), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .ovf_flag(ovf_flag));

  task automatic check(string tag);
    total++;
    if (cnt_q !== m_cnt || ovf_flag !== m_flag) begin
      bad++;
      $display("FAIL %s: cnt=%0d flag=%0b expected cnt=%0d flag=%0b",
               tag, cnt_q, ovf_flag, m_cnt, m_flag);
    end
  endtask

  task automatic step(string tag, logic [NSRC-1:0] tk, logic [SELW-1:0] sel,
                      logic pm, logic dn, logic [1:0] cs, logic ea, logic eb,
                      logic wr, logic [W-1:0] wd, logic rd, logic fw, logic fd);
    logic tick, clr, down, set;
    @(negedge clk);
    src_tick = tk; clk_sel = sel; phase_mode = pm; count_down = dn;
    clr_sel = cs; evt_a = ea; evt_b = eb; cnt_wr = wr; cnt_wdata = wd;
    flag_rd = rd; flag_wr = fw; flag_wdata = fd;
    tick = tk[sel];
    clr  = (cs == 2'd1 && ea) || (cs == 2'd2 && eb);
    down = pm && dn;
    set  = !wr && !clr && tick && (down ? (m_cnt == 0) : (m_cnt == TOP));
    if (set) m_flag_n(1'b1);
    else if (fw && !fd && m_arm) m_flag_n(1'b0);
    else m_flag_n(m_flag);
    if (fw) m_arm = 0; else if (rd) m_arm = m_flag;
    if (wr) m_cnt = wd;
    else if (clr) m_cnt = '0;
    else if (tick) m_cnt = down ? m_cnt - 1'b1 : m_cnt + 1'b1;
    m_flag = m_flag_next;
    @(posedge clk); #1;
    check(tag);
  endtask

  logic m_flag_next;
  task automatic m_flag_n(logic v); m_flag_next = v; endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load(string tag, logic [W-1:0] v);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 1, v, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1; check("R1 reset");
    rst_n = 1;
    idle("R1 idle after reset");

    // R2: only the selected source advances
    for (int s = 0; s < NSRC; s++)
      for (int t = 0; t < NSRC; t++)
        step("R2 source select", 4'(1 << t), 2'(s), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R3: up only in normal mode even with count_down=1
    load("R7 load", 4'd5);
    for (int i = 0; i < 3; i++) step("R3 up in normal mode", 4'hF, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R3 down in phase mode", 4'hF, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);

    // R4: overflow sweep from every start value
    for (int v = 0; v < 16; v++) begin
      load("R7 load", 4'(v));
      for (int i = 0; i < 16 - v; i++) step("R4 overflow", 4'h1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    end
    // R9: write 0 without armed read keeps flag
    step("R9 unarmed write", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R8: armed read then write 0 clears
    step("R8 read sees 1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R8 write 0 clears", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R9: read returning 0 cancels arm
    step("R9 read while 0", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R5: underflow
    load("R7 load", 4'd0);
    step("R5 underflow", 4'h2, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8 arm", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R9 write 1 consumes arm", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R9 consumed arm keeps flag", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R10: set and valid clear collide
    step("R8 arm", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    load("R7 load", TOP);
    step("R8 arm", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R10 set wins", 4'h1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);

    // R6: every clear-source code vs both events, with a tick
    for (int c = 0; c < 4; c++)
      for (int e = 0; e < 4; e++) begin
        load("R7 load", 4'd9);
        step("R6 event clear", 4'h1, 0, 0, 0, 2'(c), e[0], e[1], 0, 0, 0, 0, 0);
      end
    load("R7 load", TOP);
    step("R6 clear beats wrap", 4'h1, 0, 0, 0, 2'd1, 1, 0, 0, 0, 0, 0, 0);
    // R7: write beats clear and tick
    step("R7 write priority", 4'h1, 0, 0, 0, 2'd2, 0, 1, 1, 4'd7, 0, 0, 0);
    load("R7 load", TOP);
    step("R7 write beats wrap", 4'h1, 0, 0, 0, 0, 0, 0, 1, 4'd3, 0, 0, 0);

    // mixed pseudo-random sweep
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      logic [15:0] r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr ^ 16'(i * 40503);
      step("R2 R3 R4 R5 R6 R8 R9 R10 mixed", r[3:0], r[5:4], r[6], r[7], r[9:8],
           r[10] & r[11], r[12] & r[11], (r[15:12] == 4'hF), r[3:0],
           r[13], r[14] & r[1], r[2] & r[0]);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule